// File: doc/BRIEF.md
# In-Reset Serial Programming Command Slave

This block lets a host load and inspect a small on-chip program store over a four-wire serial link while the rest of the device is held in reset. The host owns the serial clock and shifts four-byte instruction frames in, most significant bit first. The slave oversamples the serial clock with its own system clock. It assembles each frame, decodes the instruction and, for read instructions, drives the answer out during the fourth byte.

The store holds 512 words of 16 bits, and each word is addressed as two byte lanes. Two lock bits guard it. A session must open with an enable frame. After that the host can read or program single bytes, read or tighten the lock bits, and wipe the whole store. Programming does not model real flash timing. Instead, a write starts a busy window of fixed length. During that window the byte being programmed reads back as all ones, so the host can poll until the written value appears.

Top module: `isp_cmd_slave`

## Requirements
- R1: A frame is four bytes, MSB first. MOSI is captured on each SCK rising edge and MISO changes only after SCK falling edges. MISO is 0 during bytes 1 to 3, after the frame and while `hold_i` is low. Each SCK phase lasts more than two system clocks.
- R2: The frame 0xAC, 0x53, x, x opens a session. Until then every other frame has no effect and answers 0x00. Driving `hold_i` low closes the session and discards any partial frame.
- R3: Read byte is byte 1 = 0010 H000, that is 0x20 for the low lane or 0x28 for the high lane. The word address is {byte2 bit 0, byte3}, and the selected byte is returned in byte 4. A byte never written since the last wipe reads 0xFF.
- R4: Write byte is byte 1 = 0100 H000, that is 0x40 or 0x48, with the same address layout. Byte 4 is the data, and after the busy window a read returns it.
- R5: While the busy window runs, a read of the byte being programmed returns 0xFF. Reads of any other byte return their true value.
- R6: An accepted write opens a busy window of BUSY_CYC system clocks. A write frame that ends inside the window is discarded.
- R7: Read lock is byte 1 = 0x58. It returns {5'b0, L2, L1, 1'b0}, where 1 means unprogrammed. Write lock is 0xAC with a byte 2 of the form 111x_xAB x. It clears L2 where A = 0 and L1 where B = 0, and never sets a bit back to 1.
- R8: While either lock bit is 0, write-byte frames are discarded.
- R9: Wipe is 0xAC with byte 2 bits [7:5] = 100. It makes every byte read 0xFF, restores both lock bits to 1 and ends any running busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | High while the device is held in reset and programming is allowed |
| sck_i | input | 1 | Serial clock from the host |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |

## Verification
Two functions meet in one cycle when the busy countdown is still live while a read header is being answered. The slave must then choose between the stored byte and the all-ones polling value. The bench provokes this by issuing reads right after a write, first of the byte under programming and then of a different byte, and checks that only the first answers 0xFF. A second collision is a wipe that lands while a countdown is running. That is provoked by a write, an immediate wipe and a second write, and it is judged by whether the second write is kept.

// File: rtl/isp_pkg.sv
package isp_pkg;

   localparam logic [7:0] K_PREFIX = 8'hAC;
   localparam logic [7:0] K_OPEN   = 8'h53;
   localparam logic [7:0] K_READ   = 8'h20;
   localparam logic [7:0] K_WRITE  = 8'h40;
   localparam logic [7:0] K_LOCKRD = 8'h58;
   localparam int         LANE_BIT = 3;
   localparam logic [7:0] LANE_MSK = ~(8'h01 << LANE_BIT);

   typedef enum logic [2:0] {
      C_NONE, C_OPEN, C_WIPE, C_LOCKWR, C_WRITE, C_READ, C_LOCKRD
   } cmd_e;

   function automatic cmd_e classify(input logic [7:0] b1, input logic [7:0] b2);
      cmd_e c;
      c = C_NONE;
      if (b1 == K_PREFIX) begin
         if (b2 == K_OPEN)             c = C_OPEN;
         else if (b2[7:5] == 3'b100)   c = C_WIPE;
         else if (b2[7:5] == 3'b111)   c = C_LOCKWR;
      end else if ((b1 & LANE_MSK) == K_READ)  c = C_READ;
      else if ((b1 & LANE_MSK) == K_WRITE)     c = C_WRITE;
      else if (b1 == K_LOCKRD)                 c = C_LOCKRD;
      return c;
   endfunction

endpackage

// File: rtl/isp_sync.sv
module isp_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("isp_sync needs at least two stages");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("isp_sync needs a nonzero width");
      end
   endgenerate

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/isp_frame.sv
module isp_frame #(
   parameter int FRAME_BYTES = 4,
   localparam int FRAME_BITS = FRAME_BYTES * 8,
   localparam int CW         = $clog2(FRAME_BITS),
   localparam int HDR_BITS   = FRAME_BITS - 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  hold_i,
   input  logic                  sck_s,
   input  logic                  mosi_s,
   input  logic [7:0]            rsp_i,
   output logic [FRAME_BITS-1:0] sr_o,
   output logic                  hdr_go_o,
   output logic                  frame_go_o,
   output logic                  miso_o
);
   generate
      if (FRAME_BYTES < 2) begin : g_bad_frame
         $error("isp_frame needs at least two bytes per frame");
      end
   endgenerate

   logic                  sck_d_q;
   logic [CW-1:0]         cnt_q;
   logic [FRAME_BITS-1:0] sr_q;
   logic [7:0]            tx_q;
   logic                  miso_q, hdr_q, done_q;
   logic                  rise, fall;

   assign rise = hold_i &  sck_s & ~sck_d_q;
   assign fall = hold_i & ~sck_s &  sck_d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d_q <= 1'b0;
         cnt_q   <= '0;
         sr_q    <= '0;
         tx_q    <= '0;
         miso_q  <= 1'b0;
         hdr_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         sck_d_q <= sck_s;
         if (!hold_i) begin
            cnt_q  <= '0;
            sr_q   <= '0;
            tx_q   <= '0;
            miso_q <= 1'b0;
            hdr_q  <= 1'b0;
            done_q <= 1'b0;
         end else begin
            hdr_q  <= rise && (cnt_q == CW'(HDR_BITS - 1));
            done_q <= rise && (cnt_q == CW'(FRAME_BITS - 1));
            if (rise) begin
               sr_q  <= {sr_q[FRAME_BITS-2:0], mosi_s};
               cnt_q <= (cnt_q == CW'(FRAME_BITS - 1)) ? '0 : cnt_q + 1'b1;
            end
            if (hdr_q) begin
               tx_q <= rsp_i;
            end else if (fall) begin
               miso_q <= tx_q[7];
               tx_q   <= {tx_q[6:0], 1'b0};
            end
         end
      end
   end

   assign sr_o       = sr_q;
   assign hdr_go_o   = hdr_q;
   assign frame_go_o = done_q;
   assign miso_o     = miso_q;

   p_miso_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_i |=> (miso_q == 1'b0));

   p_miso_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_i && !fall) |=> $stable(miso_q));

   p_count_moves_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_i && rise) |=> (cnt_q != $past(cnt_q)));

   p_hdr_done_apart_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(hdr_q && done_q));
endmodule

// File: rtl/isp_core.sv
module isp_core
   import isp_pkg::*;
#(
   parameter int ADDR_W   = 9,
   parameter int BUSY_CYC = 2000,
   localparam int DEPTH   = 1 << ADDR_W,
   localparam int BW      = $clog2(BUSY_CYC + 1),
   localparam int BA_W    = ADDR_W + 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        hold_i,
   input  logic [31:0] sr_i,
   input  logic        hdr_go_i,
   input  logic        frame_go_i,
   output logic [7:0]  rsp_o
);
   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
         $error("isp_core address width must be 9 to 16");
      end
      if (BUSY_CYC < 1) begin : g_bad_busy
         $error("isp_core busy window must be at least one cycle");
      end
   endgenerate

   logic          en_q;
   logic [1:0]    lk_q;
   logic [BW-1:0] busy_q;
   logic [BA_W-1:0] bba_q;

   // header view: first three bytes, present when hdr_go_i pulses
   cmd_e            hcmd;
   logic [15:0]     h_word;
   logic [ADDR_W-1:0] h_addr;
   logic            h_lane;
   logic [BA_W-1:0] h_ba;

   assign hcmd   = classify(sr_i[23:16], sr_i[15:8]);
   assign h_word = sr_i[15:0];
   assign h_addr = h_word[ADDR_W-1:0];
   assign h_lane = sr_i[16 + LANE_BIT];
   assign h_ba   = {h_addr, h_lane};

   // full frame view: present when frame_go_i pulses
   cmd_e            fcmd;
   logic [15:0]     f_word;
   logic [ADDR_W-1:0] f_addr;
   logic            f_lane;
   logic [7:0]      f_b2, f_data;

   assign fcmd   = classify(sr_i[31:24], sr_i[23:16]);
   assign f_word = sr_i[23:8];
   assign f_addr = f_word[ADDR_W-1:0];
   assign f_lane = sr_i[24 + LANE_BIT];
   assign f_b2   = sr_i[23:16];
   assign f_data = sr_i[7:0];

   logic go_open, go_wipe, go_lkwr, go_wr, busy;
   assign busy    = (busy_q != '0);
   assign go_open = frame_go_i && (fcmd == C_OPEN);
   assign go_wipe = frame_go_i && en_q && (fcmd == C_WIPE);
   assign go_lkwr = frame_go_i && en_q && (fcmd == C_LOCKWR);
   assign go_wr   = frame_go_i && en_q && (fcmd == C_WRITE) && !busy && (lk_q == 2'b11);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         lk_q   <= 2'b11;
         busy_q <= '0;
         bba_q  <= '0;
      end else begin
         if (!hold_i)      en_q <= 1'b0;
         else if (go_open) en_q <= 1'b1;

         if (go_wipe)      lk_q <= 2'b11;
         else if (go_lkwr) lk_q <= lk_q & f_b2[2:1];

         if (go_wipe) begin
            busy_q <= '0;
         end else if (go_wr) begin
            busy_q <= BW'(BUSY_CYC);
            bba_q  <= {f_addr, f_lane};
         end else if (busy) begin
            busy_q <= busy_q - 1'b1;
         end
      end
   end

   // two byte lanes, each with its own storage and blank map
   logic [7:0] lane_rd    [2];
   logic       lane_blank [2];

   generate
      for (genvar L = 0; L < 2; L++) begin : g_lane
         logic [7:0]       mem [DEPTH];
         logic [DEPTH-1:0] blank_q;

         always_ff @(posedge clk) begin
            if (go_wr && f_lane == 1'(L)) mem[f_addr] <= f_data;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          blank_q <= '1;
            else if (go_wipe)                    blank_q <= '1;
            else if (go_wr && f_lane == 1'(L))   blank_q[f_addr] <= 1'b0;
         end

         assign lane_rd[L]    = mem[h_addr];
         assign lane_blank[L] = blank_q[h_addr];
      end
   endgenerate

   always_comb begin
      rsp_o = 8'h00;
      if (en_q) begin
         case (hcmd)
            C_READ: begin
               if (busy && bba_q == h_ba)  rsp_o = 8'hFF;
               else if (lane_blank[h_lane]) rsp_o = 8'hFF;
               else                         rsp_o = lane_rd[h_lane];
            end
            C_LOCKRD: rsp_o = {5'b0, lk_q, 1'b0};
            default:  rsp_o = 8'h00;
         endcase
      end
   end

   p_busy_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q <= BW'(BUSY_CYC));

   p_busy_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_go_i |=> (busy_q <= $past(busy_q)));

   p_lock_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_go_i && fcmd == C_WIPE) |=> ((lk_q & ~$past(lk_q)) == 2'b00));

   p_lock_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_q != 2'b11) |=> (busy_q <= $past(busy_q)));

   p_closed_no_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> $stable(lk_q));

   p_hdr_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !hdr_go_i || !frame_go_i);
endmodule

// File: rtl/isp_cmd_slave.sv
module isp_cmd_slave #(
   parameter int ADDR_W      = 9,
   parameter int BUSY_CYC    = 2000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   input  logic sck_i,
   input  logic mosi_i,
   output logic miso_o
);
   logic [1:0]  pins_s;
   logic [31:0] sr;
   logic        hdr_go, frame_go;
   logic [7:0]  rsp;

   isp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({sck_i, mosi_i}),
      .q_o   (pins_s)
   );

   isp_frame #(.FRAME_BYTES(4)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold_i     (hold_i),
      .sck_s      (pins_s[1]),
      .mosi_s     (pins_s[0]),
      .rsp_i      (rsp),
      .sr_o       (sr),
      .hdr_go_o   (hdr_go),
      .frame_go_o (frame_go),
      .miso_o     (miso_o)
   );

   isp_core #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold_i     (hold_i),
      .sr_i       (sr),
      .hdr_go_i   (hdr_go),
      .frame_go_i (frame_go),
      .rsp_o      (rsp)
   );
endmodule

// File: tb/isp_cmd_slave_tb.sv
module isp_cmd_slave_tb;
   localparam int HALF = 6;
   localparam int BUSY = 2000;

   logic clk = 1'b0, rst_n = 1'b0, hold = 1'b0, sck = 1'b0, mosi = 1'b0;
   logic miso;
   always #2 clk = ~clk;

   isp_cmd_slave #(.ADDR_W(9), .BUSY_CYC(BUSY)) u_dut (
      .clk(clk), .rst_n(rst_n), .hold_i(hold),
      .sck_i(sck), .mosi_i(mosi), .miso_o(miso)
   );

   int n_vec = 0, n_bad = 0;
   logic [7:0] exp_q [$];
   bit         chk_q [$];
   string      tag_q [$];

   // monitor: collect host-side bits, compare each frame with the scoreboard
   logic [31:0] rx = '0;
   int          nb = 0;
   logic [7:0]  m_e;
   bit          m_c;
   string       m_t;
   always @(posedge sck) begin
      rx = {rx[30:0], miso};
      nb++;
      if (nb == 32) begin
         nb = 0;
         if (exp_q.size() > 0) begin
            m_e = exp_q.pop_front();
            m_c = chk_q.pop_front();
            m_t = tag_q.pop_front();
            if (m_c) begin
               n_vec++;
               if (rx[7:0] !== m_e || rx[31:8] !== 24'h0) begin
                  n_bad++;
                  $display("FAIL %s: got %h expected %h (bytes 1-3 must be 0)", m_t, rx, {24'h0, m_e});
               end
            end
         end
      end
   end

   task automatic frame(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                        input logic [7:0] d, input bit chk, input logic [7:0] e, input string tag);
      logic [31:0] w;
      w = {a, b, c, d};
      exp_q.push_back(e); chk_q.push_back(chk); tag_q.push_back(tag);
      for (int i = 31; i >= 0; i--) begin
         mosi = w[i];
         repeat (HALF) @(negedge clk);
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic open_s(input string tag);
      frame(8'hAC, 8'h53, 8'h00, 8'h00, 1'b1, 8'h00, tag);
   endtask
   task automatic rd(input logic [8:0] ad, input bit h, input logic [7:0] e, input string tag);
      frame(8'h20 | {4'b0, h, 3'b0}, {7'b0, ad[8]}, ad[7:0], 8'h00, 1'b1, e, tag);
   endtask
   task automatic wr(input logic [8:0] ad, input bit h, input logic [7:0] v);
      frame(8'h40 | {4'b0, h, 3'b0}, {7'b0, ad[8]}, ad[7:0], v, 1'b1, 8'h00, "R4 write answer");
   endtask
   task automatic lkrd(input logic [7:0] e, input string tag);
      frame(8'h58, 8'h00, 8'h00, 8'h00, 1'b1, e, tag);
   endtask
   task automatic lkwr(input logic [7:0] b2);
      frame(8'hAC, b2, 8'h00, 8'h00, 1'b1, 8'h00, "R7 lock write answer");
   endtask
   task automatic wipe();
      frame(8'hAC, 8'h80, 8'h00, 8'h00, 1'b1, 8'h00, "R9 wipe answer");
   endtask
   task automatic wait_busy();
      repeat (BUSY + 100) @(negedge clk);
   endtask

   initial begin
      fork
         begin : main
            repeat (5) @(negedge clk);
            rst_n = 1'b1;
            repeat (3) @(negedge clk);
            n_vec++;
            if (miso !== 1'b0) begin
               n_bad++;
               $display("FAIL R1 reset: miso got %b expected 0", miso);
            end
            hold = 1'b1;
            repeat (4) @(negedge clk);

            // R2: session closed
            rd(9'h1A0, 1'b1, 8'h00, "R2 read before open");
            frame(8'h40, 8'h00, 8'hF0, 8'h99, 1'b1, 8'h00, "R2 write before open");
            lkrd(8'h00, "R2 lock read before open");
            open_s("R1 open answer");
            rd(9'h0F0, 1'b0, 8'hFF, "R2 pre-open write ignored");

            // R3 R4
            wr(9'h1A0, 1'b1, 8'h81);
            wait_busy();
            rd(9'h1A0, 1'b1, 8'h81, "R4 high lane readback");
            rd(9'h1A0, 1'b0, 8'hFF, "R3 untouched low lane blank");

            // R5 R6
            wr(9'h005, 1'b0, 8'h3C);
            rd(9'h005, 1'b0, 8'hFF, "R5 poll while busy");
            rd(9'h1A0, 1'b1, 8'h81, "R5 other byte true value");
            wr(9'h006, 1'b0, 8'h77);
            wait_busy();
            rd(9'h005, 1'b0, 8'h3C, "R5 value after window");
            rd(9'h006, 1'b0, 8'hFF, "R6 write during window discarded");

            // R7 R8
            lkrd(8'h06, "R7 lock initial");
            lkwr(8'hE4);
            lkrd(8'h04, "R7 lock after clear");
            lkwr(8'hE6);
            lkrd(8'h04, "R7 lock cannot return");
            wr(9'h010, 1'b0, 8'h55);
            wait_busy();
            rd(9'h010, 1'b0, 8'hFF, "R8 write blocked by lock");

            // R9
            wipe();
            lkrd(8'h06, "R9 lock restored");
            rd(9'h1A0, 1'b1, 8'hFF, "R9 high byte wiped");
            rd(9'h005, 1'b0, 8'hFF, "R9 low byte wiped");
            wr(9'h010, 1'b0, 8'h55);
            wait_busy();
            rd(9'h010, 1'b0, 8'h55, "R8 write allowed after wipe");
            wr(9'h011, 1'b1, 8'hA5);
            wipe();
            wr(9'h011, 1'b1, 8'h5A);
            wait_busy();
            rd(9'h011, 1'b1, 8'h5A, "R9 wipe ends busy window");

            // R2: hold low closes session
            hold = 1'b0;
            repeat (10) @(negedge clk);
            n_vec++;
            if (miso !== 1'b0) begin
               n_bad++;
               $display("FAIL R1 hold low: miso got %b expected 0", miso);
            end
            hold = 1'b1;
            repeat (4) @(negedge clk);
            rd(9'h011, 1'b1, 8'h00, "R2 hold low closes session");
            open_s("R1 reopen answer");
            rd(9'h011, 1'b1, 8'h5A, "R2 store kept across hold");
            repeat (20) @(negedge clk);
         end
         begin
            repeat (200000) @(posedge clk);
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule